// File: doc/BRIEF.md
# Timestamp-Aligned Multi-Stream Block Joiner

The block takes several packetised input streams that carry the same kind of data at slightly different delays. Each stream delivers blocks framed by start and end markers, and each block carries a 48-bit block sequence number (BSN) on its first word. Each input writes into its own FIFO. The FIFO accepts only whole blocks and throttles its source through a per-input block-level xon flag. A control state machine looks at the first word of each FIFO. It throws away whole blocks whose BSN is behind the newest head. When all heads show the same BSN, it pops all FIFOs together, so the matching blocks leave side by side on one wide output word.

The output has no backpressure, so the design is driven by the data. When the streams disagree in the middle of a block (one stream ends its block early), the joiner ends the output block at that word. It then empties every FIFO before it tries to align again. No timeout is involved and no FIFO is ever cleared by a reset.

The controller has four states. `ST_WAIT` idles until every FIFO holds a complete block, then moves to `ST_DROP` if any head BSN is behind or to `ST_EMIT` if all heads match. `ST_DROP` pops the lagging streams until each has removed exactly one block, then returns to `ST_WAIT`. `ST_EMIT` pops all streams each cycle. It returns to `ST_WAIT` when all streams end their block on the same word, and goes to `ST_FLUSH` when only some of them do. `ST_FLUSH` pops every non-empty FIFO and returns to `ST_WAIT` once all of them are empty in the same cycle.

Top module: `bsn_stream_joiner`

## Requirements
- R1: After reset `out_valid`, `out_sop`, `out_eop` and `out_sync` are 0, every bit of `in_xon` is 1, and nothing is emitted until every input has delivered a complete block.
- R2: Blocks whose head BSNs are all equal are emitted word by word in lockstep, in input order. Stream i occupies `out_data[i*DATA_W +: DATA_W]`. `out_sop` marks the first word, `out_eop` marks the last word, and `out_bsn` equals the common BSN on the first word.
- R3: When the head BSNs differ, every head whose BSN is smaller (unsigned, 48 bits) than the largest head BSN loses exactly one whole block. Heads are compared again after each such round, until all heads match.
- R4: An input block is discarded at its FIFO in three cases: a new sop arrives before its eop, it grows past BLK_MAX words, or its start was refused. Words that arrive with valid high but outside a block (no sop) are ignored.
- R5: A block is accepted only when its FIFO has at least BLK_MAX free words at its sop. Otherwise the whole block is dropped, so a FIFO never overflows.
- R6: `in_xon[i]` is low while FIFO i has fewer than BLK_MAX+2 free words, with a lag of one clock, and returns high once the FIFO is drained.
- R7: `out_sync` is 1 on a first output word only if every input had sync set on the first word of its aligned block.
- R8: If some but not all streams end their block on the same word, that output word carries `out_eop`. All FIFOs are then read until they are empty at the same time, the rest of their contents is discarded, and alignment starts over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of pointers and state |
| in_valid | input | N_IN | Word strobe per input |
| in_sop | input | N_IN | First word of a block per input |
| in_eop | input | N_IN | Last word of a block per input |
| in_sync | input | N_IN | Sync marker per input, on the first word |
| in_bsn | input | N_IN*BSN_W | BSN per input, stream i at [i*BSN_W +: BSN_W] |
| in_data | input | N_IN*DATA_W | Data per input, stream i at [i*DATA_W +: DATA_W] |
| in_xon | output | N_IN | Block-level permission per source |
| out_valid | output | 1 | Aligned word strobe |
| out_sop | output | 1 | First word of an aligned block |
| out_eop | output | 1 | Last word of an aligned block |
| out_sync | output | 1 | Sync seen on all inputs for this block |
| out_bsn | output | BSN_W | BSN of the aligned block |
| out_data | output | N_IN*DATA_W | Concatenated data of all inputs |

## Verification
Two things can happen in the same FIFO cycle: a new block being written in (or rewound, when its start is refused or superseded) and the controller popping an older block for emission or discard. The bench provokes this with back-to-back aligned blocks, and with a fresh sop that arrives on one input while the controller is dropping lagging blocks on the others. A scoreboard judges the result. Every emitted word must match the queued expectation in order. Nothing may come out of a block that should have been discarded. xon must fall and recover at the free-space threshold.

// File: rtl/bsn_join_pkg.sv
package bsn_join_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_DROP  = 2'd1,
        ST_EMIT  = 2'd2,
        ST_FLUSH = 2'd3
    } join_state_e;
endpackage

// File: rtl/bsn_join_fifo.sv
module bsn_join_fifo #(
    parameter int DATA_W  = 16,
    parameter int BSN_W   = 48,
    parameter int DEPTH   = 32,
    parameter int BLK_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sync,
    input  logic [BSN_W-1:0]  in_bsn,
    input  logic [DATA_W-1:0] in_data,
    output logic              xon,
    input  logic              pop,
    output logic              hd_valid,
    output logic              hd_sop,
    output logic              hd_eop,
    output logic              hd_sync,
    output logic [BSN_W-1:0]  hd_bsn,
    output logic [DATA_W-1:0] hd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int EW = DATA_W + BSN_W + 3;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] BLK_P   = PW'(BLK_MAX);
    localparam logic [PW-1:0] XON_P   = PW'(BLK_MAX + 2);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, wr_base, rd_ptr;
    logic          in_blk;
    logic [PW-1:0] free_tent, free_base, blk_len;
    logic          acc_sop, we;
    logic [AW-1:0] waddr;
    logic [EW-1:0] head;

    assign free_tent = DEPTH_P - (wr_ptr - rd_ptr);
    assign free_base = DEPTH_P - (wr_base - rd_ptr);
    assign blk_len   = wr_ptr - wr_base;
    assign acc_sop   = free_base >= BLK_P;

    always_comb begin
        we    = 1'b0;
        waddr = wr_ptr[AW-1:0];
        if (in_valid) begin
            if (in_sop) begin
                we    = acc_sop;
                waddr = wr_base[AW-1:0];
            end else if (in_blk && blk_len < BLK_P) begin
                we = 1'b1;
            end
        end
    end

    // storage has no reset: it is emptied only by reading
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= {in_sop, in_eop, in_sync, in_bsn, in_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_base <= '0;
            rd_ptr  <= '0;
            in_blk  <= 1'b0;
            xon     <= 1'b1;
        end else begin
            if (in_valid) begin
                if (in_sop) begin
                    if (acc_sop) begin
                        wr_ptr <= wr_base + 1'b1;
                        if (in_eop) begin
                            wr_base <= wr_base + 1'b1;
                            in_blk  <= 1'b0;
                        end else begin
                            in_blk  <= 1'b1;
                        end
                    end else begin
                        wr_ptr <= wr_base;
                        in_blk <= 1'b0;
                    end
                end else if (in_blk) begin
                    if (blk_len < BLK_P) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        if (in_eop) begin
                            wr_base <= wr_ptr + 1'b1;
                            in_blk  <= 1'b0;
                        end
                    end else begin
                        wr_ptr <= wr_base;
                        in_blk <= 1'b0;
                    end
                end
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            xon <= free_tent >= XON_P;
        end
    end

    assign head     = mem[rd_ptr[AW-1:0]];
    assign hd_valid = rd_ptr != wr_base;
    assign hd_sop   = head[EW-1];
    assign hd_eop   = head[EW-2];
    assign hd_sync  = head[EW-3];
    assign hd_bsn   = head[DATA_W +: BSN_W];
    assign hd_data  = head[DATA_W-1:0];

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - rd_ptr) <= DEPTH_P);

    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> hd_valid);
endmodule

// File: rtl/bsn_join_ctrl.sv
module bsn_join_ctrl
    import bsn_join_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int DATA_W = 16,
    parameter int BSN_W  = 48
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IN-1:0]              hd_valid,
    input  logic [N_IN-1:0]              hd_sop,
    input  logic [N_IN-1:0]              hd_eop,
    input  logic [N_IN-1:0]              hd_sync,
    input  logic [N_IN-1:0][BSN_W-1:0]   hd_bsn,
    input  logic [N_IN-1:0][DATA_W-1:0]  hd_data,
    output logic [N_IN-1:0]              pop,
    output logic                         out_valid,
    output logic                         out_sop,
    output logic                         out_eop,
    output logic                         out_sync,
    output logic [BSN_W-1:0]             out_bsn,
    output logic [N_IN*DATA_W-1:0]       out_data
);
    join_state_e     st, nxt;
    logic [N_IN-1:0] drop_q, lag;
    logic [BSN_W-1:0] newest;
    logic            bsn_eq, emit;

    always_comb begin
        newest = hd_bsn[0];
        for (int i = 1; i < N_IN; i++) begin
            if (hd_bsn[i] > newest) newest = hd_bsn[i];
        end
        bsn_eq = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            lag[i] = hd_bsn[i] < newest;
            if (hd_bsn[i] != hd_bsn[0]) bsn_eq = 1'b0;
        end
    end

    always_comb begin
        nxt = st;
        pop = '0;
        unique case (st)
            ST_WAIT: begin
                if (&hd_valid) nxt = (|lag) ? ST_DROP : ST_EMIT;
            end
            ST_DROP: begin
                pop = drop_q & hd_valid;
                if ((drop_q & ~(pop & hd_eop)) == '0) nxt = ST_WAIT;
            end
            ST_EMIT: begin
                pop = '1;
                if (&hd_eop)      nxt = ST_WAIT;
                else if (|hd_eop) nxt = ST_FLUSH;
            end
            ST_FLUSH: begin
                pop = hd_valid;
                if (hd_valid == '0) nxt = ST_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_WAIT;
            drop_q <= '0;
        end else begin
            st <= nxt;
            if (st == ST_WAIT)      drop_q <= lag;
            else if (st == ST_DROP) drop_q <= drop_q & ~(pop & hd_eop);
        end
    end

    assign emit = st == ST_EMIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_sync  <= 1'b0;
            out_bsn   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            out_sop   <= emit && hd_sop[0];
            out_eop   <= emit && (|hd_eop);
            out_sync  <= emit && hd_sop[0] && (&hd_sync);
            out_bsn   <= hd_bsn[0];
            for (int i = 0; i < N_IN; i++) begin
                out_data[i*DATA_W +: DATA_W] <= hd_data[i];
            end
        end
    end

    // R2
    emit_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EMIT) |-> (&hd_valid));

    // R3
    lockstep_bsn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EMIT && hd_sop[0]) |-> bsn_eq);

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLUSH) |=> !out_valid);
endmodule

// File: rtl/bsn_stream_joiner.sv
module bsn_stream_joiner #(
    parameter int N_IN    = 3,
    parameter int DATA_W  = 16,
    parameter int BSN_W   = 48,
    parameter int DEPTH   = 32,
    parameter int BLK_MAX = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_valid,
    input  logic [N_IN-1:0]           in_sop,
    input  logic [N_IN-1:0]           in_eop,
    input  logic [N_IN-1:0]           in_sync,
    input  logic [N_IN*BSN_W-1:0]     in_bsn,
    input  logic [N_IN*DATA_W-1:0]    in_data,
    output logic [N_IN-1:0]           in_xon,
    output logic                      out_valid,
    output logic                      out_sop,
    output logic                      out_eop,
    output logic                      out_sync,
    output logic [BSN_W-1:0]          out_bsn,
    output logic [N_IN*DATA_W-1:0]    out_data
);
    logic [N_IN-1:0]             hd_valid, hd_sop, hd_eop, hd_sync, pop;
    logic [N_IN-1:0][BSN_W-1:0]  hd_bsn;
    logic [N_IN-1:0][DATA_W-1:0] hd_data;

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        bsn_join_fifo #(
            .DATA_W (DATA_W),
            .BSN_W  (BSN_W),
            .DEPTH  (DEPTH),
            .BLK_MAX(BLK_MAX)
        ) fifo_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_valid(in_valid[g]),
            .in_sop  (in_sop[g]),
            .in_eop  (in_eop[g]),
            .in_sync (in_sync[g]),
            .in_bsn  (in_bsn[g*BSN_W +: BSN_W]),
            .in_data (in_data[g*DATA_W +: DATA_W]),
            .xon     (in_xon[g]),
            .pop     (pop[g]),
            .hd_valid(hd_valid[g]),
            .hd_sop  (hd_sop[g]),
            .hd_eop  (hd_eop[g]),
            .hd_sync (hd_sync[g]),
            .hd_bsn  (hd_bsn[g]),
            .hd_data (hd_data[g])
        );
    end

    bsn_join_ctrl #(
        .N_IN  (N_IN),
        .DATA_W(DATA_W),
        .BSN_W (BSN_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hd_valid (hd_valid),
        .hd_sop   (hd_sop),
        .hd_eop   (hd_eop),
        .hd_sync  (hd_sync),
        .hd_bsn   (hd_bsn),
        .hd_data  (hd_data),
        .pop      (pop),
        .out_valid(out_valid),
        .out_sop  (out_sop),
        .out_eop  (out_eop),
        .out_sync (out_sync),
        .out_bsn  (out_bsn),
        .out_data (out_data)
    );
endmodule

// File: tb/bsn_stream_joiner_tb_top.sv
`timescale 1ns/1ps
module bsn_stream_joiner_tb_top;
    localparam int N = 3;
    localparam int DW = 16;
    localparam int BW = 48;

    typedef struct packed {
        logic          sop;
        logic          eop;
        logic          sync;
        logic [BW-1:0] bsn;
        logic [N*DW-1:0] data;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0, in_sop = '0, in_eop = '0, in_sync = '0;
    logic [N*BW-1:0] in_bsn = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    in_xon;
    logic            out_valid, out_sop, out_eop, out_sync;
    logic [BW-1:0]   out_bsn;
    logic [N*DW-1:0] out_data;

    exp_t exp_q[$];
    int   nchk = 0;
    int   nfail = 0;
    int   cyc = 0;

    always #4 clk = ~clk;

    bsn_stream_joiner dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_sync(in_sync),
        .in_bsn(in_bsn), .in_data(in_data), .in_xon(in_xon),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_sync(out_sync), .out_bsn(out_bsn), .out_data(out_data)
    );

    function automatic logic [DW-1:0] mkd(input logic [BW-1:0] b, input int s, input int w);
        return {b[7:0], 4'(s), 4'(w)};
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // drive blocks on the streams in en, all starting together
    task automatic send(input logic [N-1:0] en, input logic [BW-1:0] b0, input logic [BW-1:0] b1,
                        input logic [BW-1:0] b2, input int l0, input int l1, input int l2,
                        input logic [N-1:0] sy);
        logic [BW-1:0] bs[N];
        int ln[N];
        int mx;
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        ln[0] = l0; ln[1] = l1; ln[2] = l2;
        mx = 0;
        for (int s = 0; s < N; s++) if (en[s] && ln[s] > mx) mx = ln[s];
        for (int w = 0; w < mx; w++) begin
            @(negedge clk);
            for (int s = 0; s < N; s++) begin
                in_valid[s] = en[s] && (w < ln[s]);
                in_sop[s]   = (w == 0);
                in_eop[s]   = (w == ln[s] - 1);
                in_sync[s]  = sy[s] && (w == 0);
                in_bsn[s*BW +: BW]  = bs[s];
                in_data[s*DW +: DW] = mkd(bs[s], s, w);
            end
        end
        @(negedge clk);
        in_valid = '0; in_sop = '0; in_eop = '0; in_sync = '0;
    endtask

    // one stream: words without eop, optionally without sop
    task automatic send_raw(input int s, input logic [BW-1:0] b, input int n, input logic with_sop);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            in_valid[s] = 1'b1;
            in_sop[s]   = with_sop && (w == 0);
            in_eop[s]   = 1'b0;
            in_sync[s]  = 1'b0;
            in_bsn[s*BW +: BW]  = b;
            in_data[s*DW +: DW] = mkd(b, s, w);
        end
        @(negedge clk);
        in_valid = '0; in_sop = '0;
    endtask

    task automatic expect_blk(input logic [BW-1:0] b, input int len, input int last, input logic sy);
        for (int w = 0; w < len; w++) begin
            exp_t e;
            e.sop  = (w == 0);
            e.eop  = (w == last);
            e.sync = sy && (w == 0);
            e.bsn  = b;
            for (int s = 0; s < N; s++) e.data[s*DW +: DW] = mkd(b, s, w);
            exp_q.push_back(e);
        end
    endtask

    task automatic settle(input int n, input string req);
        repeat (n) @(negedge clk);
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected word", {16'h0, out_data}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data == e.data, "R2 data", 64'(out_data), 64'(e.data));
                check(out_sop == e.sop && out_eop == e.eop, "R2/R8 sop-eop",
                      {62'h0, out_sop, out_eop}, {62'h0, e.sop, e.eop});
                if (e.sop) begin
                    check(out_bsn == e.bsn, "R2/R3 bsn", 64'(out_bsn), 64'(e.bsn));
                    check(out_sync == e.sync, "R7 sync", 64'(out_sync), 64'(e.sync));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0 && out_sop == 1'b0 && out_eop == 1'b0 && out_sync == 1'b0,
              "R1 outputs idle", 64'(out_valid), 64'd0);
        check(in_xon == 3'b111, "R1 xon", 64'(in_xon), 64'h7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 one input alone produces nothing
        send(3'b001, 48'd5, 48'd0, 48'd0, 4, 0, 0, 3'b000);
        repeat (10) @(negedge clk);
        check(out_valid == 1'b0, "R1 waits for all inputs", 64'(out_valid), 64'd0);
        // complete the set: streams 1,2 bsn 5 aligns with stream 0
        expect_blk(48'd5, 4, 3, 1'b0);
        send(3'b110, 48'd0, 48'd5, 48'd5, 0, 4, 4, 3'b000);
        settle(20, "R2 aligned block");

        // R2 back-to-back aligned blocks, R7 sync all/partial
        expect_blk(48'd10, 4, 3, 1'b1);
        send(3'b111, 48'd10, 48'd10, 48'd10, 4, 4, 4, 3'b111);
        expect_blk(48'd11, 5, 4, 1'b0);
        send(3'b111, 48'd11, 48'd11, 48'd11, 5, 5, 5, 3'b011);
        expect_blk(48'd12, 1, 0, 1'b0);
        send(3'b111, 48'd12, 48'd12, 48'd12, 1, 1, 1, 3'b000);
        settle(20, "R2 R7 consecutive blocks");

        // R3 unsigned compare with top bit set: stream0 lags by one block
        send(3'b001, 48'h8000_0000_0000, 48'd0, 48'd0, 3, 0, 0, 3'b000);
        expect_blk(48'h8000_0000_0001, 4, 3, 1'b0);
        send(3'b111, 48'h8000_0000_0001, 48'h8000_0000_0001, 48'h8000_0000_0001, 4, 4, 4, 3'b000);
        settle(20, "R3 lagging block dropped");

        // R4 partial block on stream1 and stray word on stream2 are discarded
        send_raw(1, 48'd30, 3, 1'b1);
        send_raw(2, 48'd33, 2, 1'b0);
        expect_blk(48'd31, 4, 3, 1'b0);
        send(3'b111, 48'd31, 48'd31, 48'd31, 4, 4, 4, 3'b000);
        settle(20, "R4 incomplete input block");

        // R4 overlong block (BLK_MAX+1 words) on stream0 is discarded
        send(3'b001, 48'd34, 48'd0, 48'd0, 9, 0, 0, 3'b000);
        expect_blk(48'd35, 4, 3, 1'b0);
        send(3'b111, 48'd35, 48'd35, 48'd35, 4, 4, 4, 3'b000);
        settle(20, "R4 overlong block");

        // R8 length mismatch: stream2 ends one word early
        expect_blk(48'd40, 3, 2, 1'b0);
        send(3'b111, 48'd40, 48'd40, 48'd40, 4, 4, 3, 3'b000);
        settle(20, "R8 truncated block then flush");
        expect_blk(48'd41, 4, 3, 1'b0);
        send(3'b111, 48'd41, 48'd41, 48'd41, 4, 4, 4, 3'b000);
        settle(20, "R8 realigned after flush");

        // R5 R6 fill stream0 only
        send(3'b001, 48'd50, 48'd0, 48'd0, 8, 0, 0, 3'b000);
        send(3'b001, 48'd51, 48'd0, 48'd0, 8, 0, 0, 3'b000);
        repeat (2) @(negedge clk);
        check(in_xon[0] == 1'b1, "R6 xon high with 16 free", 64'(in_xon), 64'h7);
        send(3'b001, 48'd52, 48'd0, 48'd0, 8, 0, 0, 3'b000);
        repeat (2) @(negedge clk);
        check(in_xon[0] == 1'b0, "R6 xon low with 8 free", 64'(in_xon[0]), 64'd0);
        check(in_xon[2:1] == 2'b11, "R6 other inputs keep xon", 64'(in_xon), 64'h6);
        send(3'b001, 48'd53, 48'd0, 48'd0, 8, 0, 0, 3'b000);
        // FIFO full: this block must be refused whole
        send(3'b001, 48'd54, 48'd0, 48'd0, 4, 0, 0, 3'b000);
        send(3'b110, 48'd0, 48'd54, 48'd54, 0, 4, 4, 3'b000);
        repeat (40) @(negedge clk);
        check(out_valid == 1'b0 && exp_q.size() == 0, "R5 refused block not emitted",
              64'(out_valid), 64'd0);
        check(in_xon[0] == 1'b1, "R6 xon recovers after drain", 64'(in_xon[0]), 64'd1);
        expect_blk(48'd55, 4, 3, 1'b1);
        send(3'b111, 48'd55, 48'd55, 48'd55, 4, 4, 4, 3'b111);
        settle(30, "R3 R5 realign after refused block");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule